// File: doc/BRIEF.md
# Multi-Channel Periodic Timer Bank

This block holds four independent down-counting timer channels that sit behind a simple word-addressed register port. Each channel loads a programmable reload value, counts down once per tick and, when it passes zero, reloads and emits a one-cycle trigger pulse. The same event sets a sticky flag. When interrupts are enabled for that channel, the flag drives the channel's interrupt line. Triggers keep running when interrupts are disabled, so a channel can act as a pure hardware event source.

A global off bit holds every channel idle. It resets to 1, so software must clear it before anything counts. Any channel except channel 0 can be chained. A chained channel ticks on the trigger pulse of the channel below it instead of on every clock, which multiplies the two periods. Each channel is a two-state machine: `CH_IDLE` and `CH_RUN`. The transition `start` (IDLE to RUN) is taken when the off bit is 0 and the channel's run bit is 1, and it loads the counter from the reload register. The transition `stop` (RUN to IDLE) is taken when the off bit is 1 or the run bit is 0. The self-loop `tick` (RUN to RUN) either decrements the counter or, from zero, performs `expire`.

Top module: `pit_timer_bank`

## Requirements
- R1: After reset the off bit (word 0, bit 0) reads 1, and every other register reads 0. Both `trig_o` and `irq_o` are 0.
- R2: While the off bit is 1, no channel counts, expires, sets its flag or pulses its trigger. Once the off bit is cleared, an enabled channel starts again from its reload value.
- R3: Counting runs on a clock for unchained channels. Consecutive expiries are reload+1 cycles apart. On expiry the counter takes the reload value at the next clock edge.
- R4: Channel n's configuration register is at word 6+4n. Bit 0 is run, bit 1 is interrupt enable and bit 2 is chain. Clearing run stops the count and freezes the counter. Setting run again starts the count from the reload value, and the first expiry comes reload+1 ticks after the start edge.
- R5: Each expiry drives `trig_o[n]` high for exactly the one cycle after the expiring edge. This holds whatever the interrupt-enable bit is set to.
- R6: Channel n's flag register is at word 7+4n, bit 0. Expiry sets the flag, and it stays set. Writing 1 to bit 0 clears it. Writing 0 leaves it unchanged. An expiry in the same cycle as a clear wins.
- R7: `irq_o[n]` equals the channel's flag ANDed with its interrupt-enable bit.
- R8: A chained channel n≥1 decrements once for every cycle in which `trig_o[n-1]` is high, and never otherwise. Its trigger pulse follows the lower channel's pulse by one cycle. Its period is (reload_n+1)·(reload_{n-1}+1) cycles when the lower channel is unchained.
- R9: The chain bit of channel 0 is stored and can be read back, but it has no effect. Channel 0 always counts clock cycles.
- R10: Channel n's read-only value register is at word 5+4n and returns the live count. Writes to it are ignored.
- R11: Channel n's reload register is at word 4+4n. A write to it while the channel runs does not disturb the current period. The new value is used from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| trig_o | output | NCH | One-cycle expiry pulse per channel |
| irq_o | output | NCH | Interrupt level per channel |

## Verification
The bench targets the off bit holding all channels while they are configured, a reload value written mid-period, a flag clear written with 0 versus 1, a chain bit on channel 0, and chained periods whose lower channel has a reload of zero. A design that reloaded early would shorten the current period. One that honoured channel 0's chain bit would stop channel 0 counting. One that ticked a chained channel on every clock would collapse its period to its own reload+1. Random traffic is compared cycle by cycle against a bench model of the triggers, interrupts, flags and live counts, which exposes off-by-one periods and lost or stuck flags.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    localparam int unsigned REG_CTRL   = 0;
    localparam int unsigned CTRL_OFF   = 0;
    localparam int unsigned CH_BASE    = 4;
    localparam int unsigned CH_STRIDE  = 4;
    localparam int unsigned OFS_RELOAD = 0;
    localparam int unsigned OFS_VALUE  = 1;
    localparam int unsigned OFS_CFG    = 2;
    localparam int unsigned OFS_FLAG   = 3;
    localparam int unsigned CFG_RUN    = 0;
    localparam int unsigned CFG_IE     = 1;
    localparam int unsigned CFG_CHAIN  = 2;

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        off_q,
    output logic [NCH-1:0][CNT_W-1:0]   reload_q,
    output logic [NCH-1:0]              run_q,
    output logic [NCH-1:0]              ie_q,
    output logic [NCH-1:0]              chain_q,
    output logic [NCH-1:0]              flag_clr,
    input  logic [NCH-1:0][CNT_W-1:0]   live_cnt,
    input  logic [NCH-1:0]              flag_q
);

    logic wr_stb;
    logic [NCH-1:0][DATA_W-1:0] ch_rd;
    logic [NCH-1:0]             ch_hit;

    assign wr_stb = bus_sel && bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= 1'b1;
        end else if (wr_stb && bus_addr == ADDR_W'(REG_CTRL)) begin
            off_q <= bus_wdata[CTRL_OFF];
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam int unsigned BASE = CH_BASE + CH_STRIDE * n;
        logic hit_reload, hit_cfg, hit_flag, hit_value;

        assign hit_reload = bus_addr == ADDR_W'(BASE + OFS_RELOAD);
        assign hit_value  = bus_addr == ADDR_W'(BASE + OFS_VALUE);
        assign hit_cfg    = bus_addr == ADDR_W'(BASE + OFS_CFG);
        assign hit_flag   = bus_addr == ADDR_W'(BASE + OFS_FLAG);
        assign ch_hit[n]  = hit_reload || hit_value || hit_cfg || hit_flag;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reload_q[n] <= '0;
                run_q[n]    <= 1'b0;
                ie_q[n]     <= 1'b0;
                chain_q[n]  <= 1'b0;
            end else begin
                if (wr_stb && hit_reload) begin
                    reload_q[n] <= bus_wdata[CNT_W-1:0];
                end
                if (wr_stb && hit_cfg) begin
                    run_q[n]   <= bus_wdata[CFG_RUN];
                    ie_q[n]    <= bus_wdata[CFG_IE];
                    chain_q[n] <= bus_wdata[CFG_CHAIN];
                end
            end
        end

        assign flag_clr[n] = wr_stb && hit_flag && bus_wdata[0];

        always_comb begin
            ch_rd[n] = '0;
            if (hit_reload) begin
                ch_rd[n] = DATA_W'(reload_q[n]);
            end else if (hit_value) begin
                ch_rd[n] = DATA_W'(live_cnt[n]);
            end else if (hit_cfg) begin
                ch_rd[n][CFG_RUN]   = run_q[n];
                ch_rd[n][CFG_IE]    = ie_q[n];
                ch_rd[n][CFG_CHAIN] = chain_q[n];
            end else if (hit_flag) begin
                ch_rd[n][0] = flag_q[n];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_CTRL)) begin
            bus_rdata[CTRL_OFF] = off_q;
        end
        for (int n = 0; n < NCH; n++) begin
            if (ch_hit[n]) begin
                bus_rdata = ch_rd[n];
            end
        end
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             off,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             trig,
    output logic             active
);

    ch_state_e st, nxt;
    logic      expire;

    always_comb begin
        nxt = st;
        unique case (st)
            CH_IDLE: if (!off && run) nxt = CH_RUN;   // start
            CH_RUN:  if (off || !run) nxt = CH_IDLE;  // stop
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= nxt;
    end

    assign expire = (st == CH_RUN) && (nxt == CH_RUN) && tick && (cnt == '0);
    assign active = (st == CH_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b0;
            trig <= 1'b0;
        end else begin
            if (st == CH_IDLE && nxt == CH_RUN) begin
                cnt <= reload;
            end else if (st == CH_RUN && nxt == CH_RUN && tick) begin
                cnt <= (cnt == '0) ? reload : cnt - 1'b1;
            end
            trig <= expire;
            if (expire)        flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/pit_timer_bank.sv
module pit_timer_bank
    import pit_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    trig_o,
    output logic [NCH-1:0]    irq_o
);

    logic                      off_q;
    logic [NCH-1:0][CNT_W-1:0] ch_reload;
    logic [NCH-1:0][CNT_W-1:0] ch_cnt;
    logic [NCH-1:0]            ch_run, ch_ie, ch_chain, ch_flag, ch_clr;
    logic [NCH-1:0]            ch_tick, ch_active;

    pit_regs #(
        .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .off_q(off_q), .reload_q(ch_reload), .run_q(ch_run),
        .ie_q(ch_ie), .chain_q(ch_chain), .flag_clr(ch_clr),
        .live_cnt(ch_cnt), .flag_q(ch_flag)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        if (n == 0) begin : g_base
            assign ch_tick[n] = 1'b1;
        end else begin : g_link
            assign ch_tick[n] = ch_chain[n] ? trig_o[n-1] : 1'b1;
        end

        pit_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .off(off_q), .run(ch_run[n]), .tick(ch_tick[n]),
            .reload(ch_reload[n]), .flag_clr(ch_clr[n]),
            .cnt(ch_cnt[n]), .flag(ch_flag[n]), .trig(trig_o[n]),
            .active(ch_active[n])
        );
    end

    assign irq_o = ch_flag & ch_ie;

endmodule

// File: rtl/pit_timer_bank_chk.sv
module pit_timer_bank_chk #(
    parameter int unsigned NCH   = 4,
    parameter int unsigned CNT_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      off_q,
    input logic [NCH-1:0]            active,
    input logic [NCH-1:0][CNT_W-1:0] cnt,
    input logic [NCH-1:0][CNT_W-1:0] reload,
    input logic [NCH-1:0]            ie,
    input logic [NCH-1:0]            chain,
    input logic [NCH-1:0]            flag,
    input logic [NCH-1:0]            trig_o,
    input logic [NCH-1:0]            irq_o
);

    a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        off_q && $past(off_q) |-> trig_o == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_a
        a_r3_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
            trig_o[i] |-> cnt[i] == $past(reload[i]));
        a_r5_trig_from_run: assert property (@(posedge clk) disable iff (!rst_n)
            trig_o[i] |-> $past(active[i]));
        a_r6_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
            trig_o[i] |-> flag[i]);
        a_r7_irq_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
            trig_o[i] && ie[i] |-> irq_o[i]);
        if (i > 0) begin : g_chain
            a_r8_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
                $past(active[i] && chain[i] && !trig_o[i-1]) |-> $stable(cnt[i]));
        end
    end

endmodule

bind pit_timer_bank pit_timer_bank_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .off_q(off_q), .active(ch_active),
    .cnt(ch_cnt), .reload(ch_reload), .ie(ch_ie), .chain(ch_chain),
    .flag(ch_flag), .trig_o(trig_o), .irq_o(irq_o)
);

// File: tb/sim_pit_timer_bank.sv
module sim_pit_timer_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] trig_o, irq_o;

    int checks = 0, errors = 0;
    int cyc = 0;

    pit_timer_bank u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_o(trig_o), .irq_o(irq_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench model of the requirements
    logic        m_off;
    logic [31:0] m_ld [NCH];
    logic [31:0] m_cnt[NCH];
    logic        m_en[NCH], m_ie[NCH], m_ch[NCH], m_run[NCH], m_flag[NCH], m_trig[NCH];

    function automatic logic [NCH-1:0] pack_trig();
        for (int c = 0; c < NCH; c++) pack_trig[c] = m_trig[c];
    endfunction
    function automatic logic [NCH-1:0] pack_irq();
        for (int c = 0; c < NCH; c++) pack_irq[c] = m_flag[c] & m_ie[c];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_off = 1'b1;
            for (int c = 0; c < NCH; c++) begin
                m_ld[c] = 0; m_cnt[c] = 0; m_en[c] = 0; m_ie[c] = 0;
                m_ch[c] = 0; m_run[c] = 0; m_flag[c] = 0; m_trig[c] = 0;
            end
        end else begin
            logic pt[NCH];
            logic setf[NCH];
            cyc++;
            for (int c = 0; c < NCH; c++) pt[c] = m_trig[c];
            for (int c = 0; c < NCH; c++) begin
                logic tk;
                tk = (c > 0 && m_ch[c]) ? pt[c-1] : 1'b1;
                setf[c] = 1'b0;
                m_trig[c] = 1'b0;
                if (m_off || !m_en[c]) m_run[c] = 1'b0;
                else if (!m_run[c]) begin m_run[c] = 1'b1; m_cnt[c] = m_ld[c]; end
                else if (tk) begin
                    if (m_cnt[c] == 0) begin
                        m_cnt[c] = m_ld[c]; m_trig[c] = 1'b1; m_flag[c] = 1'b1; setf[c] = 1'b1;
                    end else m_cnt[c] = m_cnt[c] - 1;
                end
            end
            if (bus_sel && bus_wr) begin
                if (bus_addr == 0) m_off = bus_wdata[0];
                else if (bus_addr >= 4 && bus_addr < 4 + 4*NCH) begin
                    int c, o;
                    c = (int'(bus_addr) - 4) / 4;
                    o = (int'(bus_addr) - 4) % 4;
                    case (o)
                        0: m_ld[c] = bus_wdata;
                        2: begin m_en[c] = bus_wdata[0]; m_ie[c] = bus_wdata[1]; m_ch[c] = bus_wdata[2]; end
                        3: if (bus_wdata[0] && !setf[c]) m_flag[c] = 1'b0;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison of the outputs (R5 triggers, R7 interrupts)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(trig_o == pack_trig(), "R5 trigger pulses", 32'(trig_o), 32'(pack_trig()));
            chk(irq_o == pack_irq(), "R7 interrupt lines", 32'(irq_o), 32'(pack_irq()));
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'(a);
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_trig(input int ch, output int stamp, output bit lower_prev);
        bit prev = 1'b0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (trig_o[ch]) begin stamp = cyc; lower_prev = prev; return; end
            prev = (ch > 0) ? trig_o[ch-1] : 1'b0;
        end
        stamp = -1; lower_prev = 1'b0;
    endtask

    task automatic quiet();
        for (int c = 0; c < NCH; c++) begin
            wr(6 + 4*c, 0);
            wr(7 + 4*c, 1);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d, d2;
        int t1, t2;
        bit lp;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, d);  chk(d == 1, "R1 off bit after reset", d, 1);
        rd(6, d);  chk(d == 0, "R1 cfg after reset", d, 0);
        rd(12, d); chk(d == 0, "R1 reload after reset", d, 0);
        chk(trig_o == 0 && irq_o == 0, "R1 outputs after reset", 32'({trig_o, irq_o}), 0);

        // R2 off bit holds everything
        wr(4, 3); wr(6, 3);
        repeat (20) @(negedge clk);
        rd(5, d); chk(d == 0, "R2 no count while off", d, 0);
        rd(7, d); chk(d == 0, "R2 no flag while off", d, 0);
        wr(0, 0);
        wait_trig(0, t1, lp); wait_trig(0, t2, lp);
        chk(t2 - t1 == 4, "R2 runs after off cleared", 32'(t2 - t1), 4);
        quiet();

        // R3 period reload+1
        wr(4, 255); wr(6, 1);
        wait_trig(0, t1, lp); wait_trig(0, t2, lp);
        chk(t2 - t1 == 256, "R3 period 256", 32'(t2 - t1), 256);

        // R11 reload change mid-period
        wr(4, 99);
        wait_trig(0, t1, lp);
        chk(t1 - t2 == 256, "R11 current period kept", 32'(t1 - t2), 256);
        wait_trig(0, t2, lp);
        chk(t2 - t1 == 100, "R11 new period used", 32'(t2 - t1), 100);

        // R4 stop freezes, restart from reload
        wr(6, 0);
        rd(5, d); repeat (10) @(negedge clk); rd(5, d2);
        chk(d == d2, "R4 count frozen when stopped", d2, d);
        wr(4, 7); wr(6, 1);
        rd(5, d); chk(d <= 7, "R4 restart from reload", d, 7);
        quiet();

        // R5 trigger with interrupts off, R6 flag behaviour, R7 irq
        wr(8, 5); wr(10, 1);
        wait_trig(1, t1, lp); wait_trig(1, t2, lp);
        chk(t2 - t1 == 6, "R5 trigger without irq enable", 32'(t2 - t1), 6);
        chk(irq_o[1] == 0, "R7 irq masked", 32'(irq_o[1]), 0);
        wr(10, 0);
        rd(11, d); chk(d == 1, "R6 flag sticky", d, 1);
        wr(11, 0); rd(11, d); chk(d == 1, "R6 write 0 keeps flag", d, 1);
        wr(10, 2); @(negedge clk);
        chk(irq_o[1] == 1, "R7 irq follows enable", 32'(irq_o[1]), 1);
        wr(11, 1); rd(11, d); chk(d == 0, "R6 write 1 clears flag", d, 0);
        quiet();

        // R10 value register live and read only
        wr(16, 50); wr(18, 1);
        rd(17, d); repeat (5) @(negedge clk); rd(17, d2);
        chk(d - d2 == 6, "R10 live count", d - d2, 6);
        wr(17, 32'hFFFF); rd(16, d); chk(d == 50, "R10 value write ignored", d, 50);
        quiet();

        // R8 chaining, R9 channel 0 chain bit ignored
        wr(4, 9); wr(6, 5);
        rd(6, d); chk(d == 5, "R9 chain bit readable", d, 5);
        wait_trig(0, t1, lp); wait_trig(0, t2, lp);
        chk(t2 - t1 == 10, "R9 channel 0 counts clocks", 32'(t2 - t1), 10);
        wr(8, 4); wr(10, 5);
        wait_trig(1, t1, lp); wait_trig(1, t2, lp);
        chk(t2 - t1 == 50, "R8 chained period", 32'(t2 - t1), 50);
        chk(lp == 1, "R8 follows lower trigger", 32'(lp), 1);
        quiet();

        // random traffic against the model
        for (int it = 0; it < 3000; it++) begin
            int c, op;
            c = $urandom_range(0, NCH-1);
            op = $urandom_range(0, 9);
            case (op)
                0, 1: wr(4 + 4*c, $urandom_range(0, 15));
                2, 3: wr(6 + 4*c, $urandom_range(0, 7));
                4:    wr(7 + 4*c, $urandom_range(0, 1));
                5:    if ($urandom_range(0, 9) == 0) begin wr(0, 1); wr(0, 0); end
                6: begin rd(5 + 4*c, d); chk(d == m_cnt[c], "R10 random live count", d, m_cnt[c]); end
                7: begin rd(7 + 4*c, d); chk(d == 32'(m_flag[c]), "R6 random flag", d, 32'(m_flag[c])); end
                default: repeat ($urandom_range(1, 6)) @(negedge clk);
            endcase
        end
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule